// File: doc/BRIEF.md
# Multicast Flit Forker for a Mesh Router

This block is the fan-out stage of one router in a two-dimensional mesh. A single flit arrives on a valid/ready input, carrying an operation code, a destination base coordinate and a per-dimension don't-care mask. A multicast flit addresses every mesh node whose X and Y coordinates agree with the base on all bits that the mask leaves clear. The block works out which of its five outputs (north, east, south, west, local) lead towards at least one of those nodes under X-then-Y dimension-order routing. It then offers an identical copy of the flit on each chosen output.

The five outputs share one data bus and have separate valid and ready lines. Each chosen output may accept its copy in a different cycle. The block remembers which copies have gone and never offers one twice. Input back-pressure rules: `in_ready` is high only in a cycle where `in_valid` is high and either every output still owed a copy accepts it now, or the flit is dropped. While `in_valid` is high and `in_ready` is low, the source must hold the flit unchanged. An output's copy is accepted when its `out_valid` and `out_ready` are both high at a rising clock edge. The outputs are driven combinationally from the input, with no register stage.

The mesh is `MESH_X` by `MESH_Y` nodes, padded to power-of-two coordinate ranges. A flit whose address set holds no node inside the mesh is swallowed, and this raises a sticky error flag that only reset clears.

Top module: `mcast_forker`

## Requirements
- R1: For operation codes other than multicast (0 unicast, 2 reduce, 3 reserved), the mask is ignored and exactly one output is chosen by XY routing. The output bits are 0 north (+Y), 1 east (+X), 2 south (−Y), 3 west (−X) and 4 local. East or west is chosen when the destination X is larger or smaller than `here_x`. Otherwise north, south or local is chosen when the destination Y is larger, smaller or equal to `here_y`.
- R2: For operation code 1 (multicast), the destination set is every node (x,y) with x < MESH_X, y < MESH_Y, ((x xor base_x) and not mask_x) = 0, and the same rule in Y.
- R3: East is chosen for a multicast exactly when some destination X exceeds `here_x`. West is chosen exactly when some destination X is below it. Non-contiguous masks may choose both.
- R4: North, south and local are chosen only when `here_x` belongs to the destination X set. North is chosen if some destination Y exceeds `here_y`, south if some destination Y is below it, and local if `here_y` itself is a destination Y.
- R5: `out_valid` for an owed output rises in the same cycle as `in_valid`. The output data and header fields equal the input fields.
- R6: The input is consumed only in the cycle when the last owed output accepts. Outputs may accept on different cycles, and each chosen output receives exactly one copy per flit.
- R7: After a flit is consumed, the delivery record clears, so the next flit is offered on all of its own chosen outputs.
- R8: A flit with no destination inside the mesh is accepted at once (`in_ready` high) with no `out_valid`. `err_flag` then goes high and stays high until reset. Flits with valid destinations never set it.
- R9: During and after reset, `err_flag` is 0, and with `in_valid` low, `out_valid` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| here_x | input | X_W | This router's X coordinate |
| here_y | input | Y_W | This router's Y coordinate |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Input flit consumed this cycle |
| in_op | input | 2 | Operation code (0 unicast, 1 multicast, 2 reduce, 3 reserved) |
| in_base_x | input | X_W | Destination base X |
| in_base_y | input | Y_W | Destination base Y |
| in_mask_x | input | X_W | Don't-care bits of X |
| in_mask_y | input | Y_W | Don't-care bits of Y |
| in_data | input | DATA_W | Flit payload |
| out_valid | output | 5 | Per-output copy valid (bit order N,E,S,W,L) |
| out_ready | input | 5 | Per-output accept |
| out_op | output | 2 | Copied operation code |
| out_base_x | output | X_W | Copied base X |
| out_base_y | output | Y_W | Copied base Y |
| out_mask_x | output | X_W | Copied mask X |
| out_mask_y | output | Y_W | Copied mask Y |
| out_data | output | DATA_W | Copied payload |
| err_flag | output | 1 | Sticky unreachable-destination flag |

## Verification
The assertions watch, on every cycle, the handshake properties that hold for any traffic. A non-multicast flit never drives more than one output. A copy, once accepted, is not offered again while its flit stalls. The input is never released while an offered copy is still refused. The error flag only rises after a flit is swallowed, and it never falls. Only the bench scenarios can show that the chosen output set matches an enumeration of the addressed nodes for particular bases and masks, including padded columns and non-contiguous masks. The same holds for staggered acceptance that ends with exactly one copy per output, and for the clearing of the delivery record between flits.

// File: rtl/mcast_pkg.sv
package mcast_pkg;
  typedef enum logic [1:0] {
    OP_UNICAST = 2'd0,
    OP_MCAST   = 2'd1,
    OP_REDUCE  = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  localparam int NPORT  = 5;
  localparam int PORT_N = 0;
  localparam int PORT_E = 1;
  localparam int PORT_S = 2;
  localparam int PORT_W = 3;
  localparam int PORT_L = 4;
endpackage

// File: rtl/mcast_route_dec.sv
module mcast_route_dec
  import mcast_pkg::*;
#(
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int MESH_X = 3,
  parameter int MESH_Y = 4
) (
  input  logic [1:0]       op,
  input  logic [X_W-1:0]   base_x,
  input  logic [Y_W-1:0]   base_y,
  input  logic [X_W-1:0]   mask_x,
  input  logic [Y_W-1:0]   mask_y,
  input  logic [X_W-1:0]   here_x,
  input  logic [Y_W-1:0]   here_y,
  output logic [NPORT-1:0] sel,
  output logic             none
);
  localparam int NX = 1 << X_W;
  localparam int NY = 1 << Y_W;

  logic [X_W-1:0] eff_mx;
  logic [Y_W-1:0] eff_my;
  logic [NX-1:0]  hit_x;
  logic [NY-1:0]  hit_y;
  logic go_e, go_w, go_n, go_s, col;

  // Mask applies only to multicast; other codes address a single node.
  assign eff_mx = (op == OP_MCAST) ? mask_x : '0;
  assign eff_my = (op == OP_MCAST) ? mask_y : '0;

  // Per-coordinate membership, with padded coordinates excluded.
  always_comb begin
    hit_x = '0;
    for (int i = 0; i < NX; i++) begin
      if (i < MESH_X && ((X_W'(i) ^ base_x) & ~eff_mx) == '0) hit_x[i] = 1'b1;
    end
    hit_y = '0;
    for (int j = 0; j < NY; j++) begin
      if (j < MESH_Y && ((Y_W'(j) ^ base_y) & ~eff_my) == '0) hit_y[j] = 1'b1;
    end
  end

  always_comb begin
    go_e = 1'b0;
    go_w = 1'b0;
    for (int i = 0; i < NX; i++) begin
      if (hit_x[i] && i > int'(here_x)) go_e = 1'b1;
      if (hit_x[i] && i < int'(here_x)) go_w = 1'b1;
    end
    go_n = 1'b0;
    go_s = 1'b0;
    for (int j = 0; j < NY; j++) begin
      if (hit_y[j] && j > int'(here_y)) go_n = 1'b1;
      if (hit_y[j] && j < int'(here_y)) go_s = 1'b1;
    end
  end

  assign col  = hit_x[here_x];
  assign none = ~|hit_x | ~|hit_y;

  always_comb begin
    sel = '0;
    if (!none) begin
      sel[PORT_E] = go_e;
      sel[PORT_W] = go_w;
      sel[PORT_N] = col & go_n;
      sel[PORT_S] = col & go_s;
      sel[PORT_L] = col & hit_y[here_y];
    end
  end
endmodule

// File: rtl/mcast_fork_ctl.sv
module mcast_fork_ctl
  import mcast_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NPORT-1:0] sel,
  input  logic             drop,
  input  logic [NPORT-1:0] out_ready,
  output logic [NPORT-1:0] out_valid,
  output logic             in_ready
);
  logic [NPORT-1:0] sent;
  logic             all_taken;

  // Every chosen output has either already taken its copy or takes it now.
  assign all_taken = &(~sel | sent | out_ready);
  assign out_valid = (in_valid && !drop) ? (sel & ~sent) : '0;
  assign in_ready  = in_valid && (drop || all_taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent <= '0;
    end else if (in_valid && in_ready) begin
      sent <= '0;
    end else if (in_valid) begin
      sent <= sent | (out_valid & out_ready);
    end
  end
endmodule

// File: rtl/mcast_forker.sv
module mcast_forker
  import mcast_pkg::*;
#(
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int MESH_X = 3,
  parameter int MESH_Y = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [X_W-1:0]    here_x,
  input  logic [Y_W-1:0]    here_y,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [X_W-1:0]    in_base_x,
  input  logic [Y_W-1:0]    in_base_y,
  input  logic [X_W-1:0]    in_mask_x,
  input  logic [Y_W-1:0]    in_mask_y,
  input  logic [DATA_W-1:0] in_data,
  output logic [4:0]        out_valid,
  input  logic [4:0]        out_ready,
  output logic [1:0]        out_op,
  output logic [X_W-1:0]    out_base_x,
  output logic [Y_W-1:0]    out_base_y,
  output logic [X_W-1:0]    out_mask_x,
  output logic [Y_W-1:0]    out_mask_y,
  output logic [DATA_W-1:0] out_data,
  output logic              err_flag
);
  logic [NPORT-1:0] route_sel;
  logic             unreachable;

  mcast_route_dec #(
    .X_W(X_W), .Y_W(Y_W), .MESH_X(MESH_X), .MESH_Y(MESH_Y)
  ) u_dec (
    .op     (in_op),
    .base_x (in_base_x),
    .base_y (in_base_y),
    .mask_x (in_mask_x),
    .mask_y (in_mask_y),
    .here_x (here_x),
    .here_y (here_y),
    .sel    (route_sel),
    .none   (unreachable)
  );

  mcast_fork_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sel       (route_sel),
    .drop      (unreachable),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .in_ready  (in_ready)
  );

  // All copies are identical, so one shared bus carries them.
  assign out_op     = in_op;
  assign out_base_x = in_base_x;
  assign out_base_y = in_base_y;
  assign out_mask_x = in_mask_x;
  assign out_mask_y = in_mask_y;
  assign out_data   = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
    end else if (in_valid && in_ready && unreachable) begin
      err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/mcast_forker_chk.sv
module mcast_forker_chk #(
  parameter int X_W = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [1:0]     in_op,
  input logic [X_W-1:0] in_base_x,
  input logic [X_W-1:0] here_x,
  input logic [4:0]     out_valid,
  input logic [4:0]     out_ready,
  input logic           err_flag
);
  // R1
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 2'd1) |-> $onehot0(out_valid));

  // R4
  unicast_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 2'd1 && (out_valid & 5'b10101) != 5'b0) |-> (in_base_x == here_x));

  // R5
  copy_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != 5'b0) |-> in_valid);

  // R6
  no_second_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ((out_valid & $past(out_valid & out_ready)) == 5'b0));

  // R6
  release_all_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ((out_valid & ~out_ready) == 5'b0));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(in_valid && in_ready && out_valid == 5'b0));
endmodule

bind mcast_forker mcast_forker_chk #(.X_W(X_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_base_x (in_base_x),
  .here_x    (here_x),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .err_flag  (err_flag)
);

// File: tb/sim_mcast_forker.sv
`timescale 1ns/1ps
module sim_mcast_forker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  here_x = '0, here_y = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0, in_base_x = '0, in_base_y = '0, in_mask_x = '0, in_mask_y = '0;
  logic [31:0] in_data = '0;
  logic [4:0]  out_valid;
  logic [4:0]  out_ready = '0;
  logic [1:0]  out_op, out_base_x, out_base_y, out_mask_x, out_mask_y;
  logic [31:0] out_data;
  logic        err_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mcast_forker u0 (
    .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_base_x(in_base_x), .in_base_y(in_base_y),
    .in_mask_x(in_mask_x), .in_mask_y(in_mask_y), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_base_x(out_base_x), .out_base_y(out_base_y),
    .out_mask_x(out_mask_x), .out_mask_y(out_mask_y), .out_data(out_data),
    .err_flag(err_flag)
  );

  // {op, bx, by, mx, my, here_x, here_y, expected outputs L W S E N, expected drop}
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 2'd2, 2'd1, 2'd0, 2'd0, 2'd1, 2'd1, 5'b00010, 1'b0},
    {2'd0, 2'd1, 2'd3, 2'd0, 2'd0, 2'd1, 2'd1, 5'b00001, 1'b0},
    {2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd1, 2'd1, 5'b10000, 1'b0},
    {2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd1, 2'd1, 5'b01000, 1'b0},
    {2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 5'b00100, 1'b0},
    {2'd1, 2'd0, 2'd0, 2'd3, 2'd3, 2'd1, 2'd1, 5'b11111, 1'b0},
    {2'd1, 2'd2, 2'd0, 2'd0, 2'd3, 2'd1, 2'd1, 5'b00010, 1'b0},
    {2'd1, 2'd1, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 5'b00100, 1'b0},
    {2'd1, 2'd1, 2'd2, 2'd0, 2'd1, 2'd1, 2'd2, 5'b10001, 1'b0},
    {2'd1, 2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 5'b10010, 1'b0},
    {2'd2, 2'd0, 2'd0, 2'd3, 2'd3, 2'd1, 2'd1, 5'b01000, 1'b0},
    {2'd3, 2'd1, 2'd1, 2'd3, 2'd3, 2'd1, 2'd1, 5'b10000, 1'b0},
    {2'd1, 2'd2, 2'd0, 2'd1, 2'd0, 2'd2, 2'd0, 5'b10000, 1'b0},
    {2'd1, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd1, 5'b01010, 1'b0},
    {2'd0, 2'd2, 2'd3, 2'd0, 2'd0, 2'd2, 2'd3, 5'b10000, 1'b0},
    {2'd1, 2'd3, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 5'b00000, 1'b1},
    {2'd0, 2'd3, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 5'b00000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Enumerate every addressed node of a 3x4 mesh and route each one by XY.
  function automatic logic [4:0] ref_sel(input logic [1:0] op, bx, by, mx, my, hx, hy);
    logic [4:0] s = '0;
    logic [1:0] ex = (op == 2'd1) ? mx : 2'd0;
    logic [1:0] ey = (op == 2'd1) ? my : 2'd0;
    for (int x = 0; x < 3; x++) begin
      for (int y = 0; y < 4; y++) begin
        if (((2'(x) ^ bx) & ~ex) == 2'd0 && ((2'(y) ^ by) & ~ey) == 2'd0) begin
          if (x > int'(hx)) s[1] = 1'b1;
          else if (x < int'(hx)) s[3] = 1'b1;
          else if (y > int'(hy)) s[0] = 1'b1;
          else if (y < int'(hy)) s[2] = 1'b1;
          else s[4] = 1'b1;
        end
      end
    end
    return s;
  endfunction

  task automatic load(input logic [19:0] v, input logic [31:0] d);
    in_op = v[19:18]; in_base_x = v[17:16]; in_base_y = v[15:14];
    in_mask_x = v[13:12]; in_mask_y = v[11:10]; here_x = v[9:8]; here_y = v[7:6];
    in_data = d; in_valid = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 err_flag in reset", 32'(err_flag), 0);
    chk("R9 out_valid idle", 32'(out_valid), 0);
    chk("R9 in_ready idle", 32'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1, R2, R3, R4, R5, R8 with all outputs ready
    for (int i = 0; i < NV; i++) begin
      load(VEC[i], 32'hC0DE0000 + 32'(i));
      out_ready = 5'b11111;
      #1;
      if (VEC[i][0]) begin
        chk("R8 dropped flit no copy", 32'(out_valid), 0);
        chk("R8 dropped flit accepted", 32'(in_ready), 1);
      end else begin
        chk("R2 R3 R4 table outputs", 32'(out_valid), 32'(VEC[i][5:1]));
        chk("R2 enumeration reference", 32'(out_valid),
            32'(ref_sel(VEC[i][19:18], VEC[i][17:16], VEC[i][15:14], VEC[i][13:12],
                        VEC[i][11:10], VEC[i][9:8], VEC[i][7:6])));
        chk("R6 single-cycle release", 32'(in_ready), 1);
        chk("R5 payload copied", out_data, 32'hC0DE0000 + 32'(i));
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 err_flag state", 32'(err_flag), (i >= 15) ? 1 : 0);
    end
    @(negedge clk);
    chk("R8 err_flag sticky", 32'(err_flag), 1);

    // R9: reset clears sticky flag
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 err_flag cleared by reset", 32'(err_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: staggered acceptance of a full five-way fork
    load(VEC[5], 32'h5A5A0001);
    out_ready = 5'b00000;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R6 stall with no accept", 32'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 5'b00101;
    #1;
    chk("R6 all copies offered", 32'(out_valid), 32'b11111);
    chk("R6 held while copies owed", 32'(in_ready), 0);
    @(negedge clk);
    out_ready = 5'b00000;
    #1;
    chk("R6 taken copies withdrawn", 32'(out_valid), 32'b11010);
    chk("R6 still held", 32'(in_ready), 0);
    @(negedge clk);
    out_ready = 5'b11010;
    #1;
    chk("R6 remaining copies", 32'(out_valid), 32'b11010);
    chk("R6 release on last accept", 32'(in_ready), 1);
    @(negedge clk);

    // R7: delivery record cleared for the next flit
    load(VEC[5], 32'h5A5A0002);
    out_ready = 5'b00000;
    #1;
    chk("R7 fresh flit offered everywhere", 32'(out_valid), 32'b11111);
    chk("R5 new payload", out_data, 32'h5A5A0002);
    @(negedge clk);
    out_ready = 5'b11111;
    #1;
    chk("R7 release", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R9 idle after traffic", 32'(out_valid), 0);
    chk("R8 no error from valid traffic", 32'(err_flag), 0);

    finished = 1'b1;
    summary();
  end
endmodule